// File: doc/BRIEF.md
# Gear-Shifting Loop Filter for an All-Digital PLL

This block is the digital loop filter of an all-digital frequency synthesizer. Once per reference period a strobe marks a new signed phase-error sample, and the filter turns it into a signed oscillator tuning word. While the loop is acquiring frequency the filter is purely proportional, which gives a type-I loop with a wide bandwidth of roughly 2 MHz. When a mode input asks for tracking, it switches to a proportional-integral (type-II) law of about 500 kHz bandwidth, followed by a cascade of first-order IIR smoothing stages (four by default). All gains are powers of two, so every gain is an arithmetic right shift and the filter has no multipliers.

Changing the gains would normally make the tuning word jump. At each change of mode the filter therefore reloads its integrator, and on entry to tracking its IIR stages as well, so that the tuning word keeps exactly the value it had before the change. The integrator and the tuning word saturate at the signed limits of the tuning-word width and never wrap. Lock detection, which drives the mode input, and the oscillator are outside this block.

Top module: `gear_loop_filter`

## Requirements
- R1: While reset is asserted, the tuning word, the integrator and every IIR stage are zero, and the filter is in acquisition mode.
- R2: State changes only in cycles where `ref_en` is high. In any other cycle the tuning word and the integrator hold, whatever `phase_err`, `track` and the shift inputs do.
- R3: On an update in acquisition mode with `track` low, the tuning word becomes sat(I + (e >>> `acq_kp_sh`)). Here e is `phase_err`, >>> is an arithmetic (floor) right shift, and I is the integrator, which does not change in acquisition mode.
- R4: On an update in acquisition mode with `track` high, the filter enters tracking mode and the tuning word keeps its value W. The integrator becomes sat(W - (e >>> `trk_kp_sh`)) and every IIR stage is loaded with W.
- R5: On an update in tracking mode with `track` high, the integrator becomes I' = sat(I + (e >>> `trk_ki_sh`)), and the proportional-integral value is P = sat(I' + (e >>> `trk_kp_sh`)).
- R6: In the same update, IIR stage i does y_i += (x_i - y_i) >>> k_i. Its shift k_i is `iir_k[i*SH_W +: SH_W]`. Stage 0 takes x = P, and stage i > 0 takes the value stage i-1 held before the update. The tuning word becomes the new value of the last stage.
- R7: On an update in tracking mode with `track` low, the filter returns to acquisition mode and the tuning word keeps its value W. The integrator becomes sat(W - (e >>> `acq_kp_sh`)).
- R8: sat() clamps to the range -2^(TW_W-1) .. 2^(TW_W-1)-1. Neither the integrator nor the tuning word wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | Update strobe, one cycle per reference period |
| track | input | 1 | 1 requests tracking mode, 0 requests acquisition |
| phase_err | input | PE_W | Signed phase error sample |
| acq_kp_sh | input | SH_W | Proportional shift in acquisition |
| trk_kp_sh | input | SH_W | Proportional shift in tracking |
| trk_ki_sh | input | SH_W | Integral shift in tracking |
| iir_k | input | N_IIR*SH_W | Per-stage IIR shifts, stage i in bits i*SH_W upward |
| tune_word | output | TW_W | Signed oscillator tuning word |

## Verification
Every result has a latency of one clock: a tuning word computed from an update strobe appears after the rising edge that samples that strobe, and so does a held value after a non-strobe cycle. The bench drives each stimulus on a falling edge and waits for one rising edge. It then compares the output on the next falling edge against an arithmetic model, which it advances by exactly one update per strobe. IIR outputs from earlier samples reach the tuning word only over several strobes, one stage per strobe. For that reason the model keeps every stage value, and the bench checks the output after every step, with no settling allowance.

// File: rtl/lf_pkg.sv
package lf_pkg;
    // Operating gear of the loop filter
    typedef enum logic {
        MODE_ACQ = 1'b0,
        MODE_TRK = 1'b1
    } lf_mode_e;
endpackage

// File: rtl/lf_shift.sv
// Power-of-two gain: sign-extends a sample and shifts it right arithmetically.
module lf_shift #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 16,
    parameter int SH_W  = 4
) (
    input  logic signed [IN_W-1:0]  val,
    input  logic        [SH_W-1:0]  sh,
    output logic signed [OUT_W-1:0] res
);
    localparam int EXT = OUT_W - IN_W;

    logic signed [OUT_W-1:0] ext;

    assign ext = {{EXT{val[IN_W-1]}}, val};
    assign res = ext >>> sh;
endmodule

// File: rtl/lf_sat_add.sv
// Add or subtract two wide operands and clamp the result to a narrower signed range.
module lf_sat_add #(
    parameter int AW = 16,
    parameter int OW = 14
) (
    input  logic signed [AW-1:0] a,
    input  logic signed [AW-1:0] b,
    input  logic                 sub,
    output logic        [OW-1:0] y
);
    localparam int PAD = AW - OW + 2;
    localparam logic signed [AW:0] HI = {{PAD{1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW:0] LO = {{PAD{1'b1}}, {(OW-1){1'b0}}};

    logic signed [AW:0] ax, bx, sum;

    always_comb begin
        ax  = {a[AW-1], a};
        bx  = {b[AW-1], b};
        sum = sub ? (ax - bx) : (ax + bx);
        if (sum > HI) begin
            y = HI[OW-1:0];
        end else if (sum < LO) begin
            y = LO[OW-1:0];
        end else begin
            y = sum[OW-1:0];
        end
    end
endmodule

// File: rtl/lf_iir_stage.sv
// First-order smoothing step: y_next = y + ((x - y) >>> k).
// The result always lies between x and y, so it cannot overflow.
module lf_iir_stage #(
    parameter int W    = 14,
    parameter int SH_W = 4
) (
    input  logic [W-1:0]    x,
    input  logic [W-1:0]    y_q,
    input  logic [SH_W-1:0] k,
    output logic [W-1:0]    y_d
);
    logic signed [W:0] diff, step, acc;

    always_comb begin
        diff = $signed({x[W-1], x}) - $signed({y_q[W-1], y_q});
        step = diff >>> k;
        acc  = $signed({y_q[W-1], y_q}) + step;
        y_d  = acc[W-1:0];
    end
endmodule

// File: rtl/gear_loop_filter.sv
module gear_loop_filter
    import lf_pkg::*;
#(
    parameter int PE_W  = 10,
    parameter int TW_W  = 14,
    parameter int SH_W  = 4,
    parameter int N_IIR = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_en,
    input  logic                  track,
    input  logic [PE_W-1:0]       phase_err,
    input  logic [SH_W-1:0]       acq_kp_sh,
    input  logic [SH_W-1:0]       trk_kp_sh,
    input  logic [SH_W-1:0]       trk_ki_sh,
    input  logic [N_IIR*SH_W-1:0] iir_k,
    output logic [TW_W-1:0]       tune_word
);
    // Width for intermediate sums: tuning-word range plus headroom
    localparam int AW  = TW_W + 2;
    localparam int EXT = AW - TW_W;

    typedef struct packed {
        lf_mode_e                     mode;
        logic [TW_W-1:0]              integ;
        logic [N_IIR-1:0][TW_W-1:0]   iir;
        logic [TW_W-1:0]              out;
    } lf_state_t;

    lf_state_t q, d;

    // Gain terms
    logic signed [AW-1:0] p_acq, p_trk, i_trk;
    // Sign-extended state operands
    logic signed [AW-1:0] integ_x, out_x, integ_trk_x;
    // Saturated results
    logic [TW_W-1:0] acq_out, preload_trk, preload_acq, integ_trk, pi_val;
    logic [N_IIR-1:0][TW_W-1:0] iir_nxt;

    // Observation points for the bound checker
    logic            mode_is_trk;
    logic [TW_W-1:0] integ_obs;

    lf_shift #(.IN_W(PE_W), .OUT_W(AW), .SH_W(SH_W)) u_sh_acq_kp (
        .val(phase_err), .sh(acq_kp_sh), .res(p_acq));
    lf_shift #(.IN_W(PE_W), .OUT_W(AW), .SH_W(SH_W)) u_sh_trk_kp (
        .val(phase_err), .sh(trk_kp_sh), .res(p_trk));
    lf_shift #(.IN_W(PE_W), .OUT_W(AW), .SH_W(SH_W)) u_sh_trk_ki (
        .val(phase_err), .sh(trk_ki_sh), .res(i_trk));

    assign integ_x     = {{EXT{q.integ[TW_W-1]}}, q.integ};
    assign out_x       = {{EXT{q.out[TW_W-1]}}, q.out};
    assign integ_trk_x = {{EXT{integ_trk[TW_W-1]}}, integ_trk};

    // Acquisition output: held integrator plus wide proportional term
    lf_sat_add #(.AW(AW), .OW(TW_W)) u_acq_out (
        .a(integ_x), .b(p_acq), .sub(1'b0), .y(acq_out));
    // Preload on entry to tracking keeps the output continuous
    lf_sat_add #(.AW(AW), .OW(TW_W)) u_pre_trk (
        .a(out_x), .b(p_trk), .sub(1'b1), .y(preload_trk));
    // Preload on return to acquisition
    lf_sat_add #(.AW(AW), .OW(TW_W)) u_pre_acq (
        .a(out_x), .b(p_acq), .sub(1'b1), .y(preload_acq));
    // Tracking integrator
    lf_sat_add #(.AW(AW), .OW(TW_W)) u_integ (
        .a(integ_x), .b(i_trk), .sub(1'b0), .y(integ_trk));
    // Tracking proportional-integral sum
    lf_sat_add #(.AW(AW), .OW(TW_W)) u_pi (
        .a(integ_trk_x), .b(p_trk), .sub(1'b0), .y(pi_val));

    // IIR cascade: each stage reads the previous stage's registered value
    for (genvar g = 0; g < N_IIR; g++) begin : g_iir
        logic [TW_W-1:0] x_in;
        if (g == 0) begin : g_head
            assign x_in = pi_val;
        end else begin : g_tail
            assign x_in = q.iir[g-1];
        end
        lf_iir_stage #(.W(TW_W), .SH_W(SH_W)) u_stage (
            .x  (x_in),
            .y_q(q.iir[g]),
            .k  (iir_k[g*SH_W +: SH_W]),
            .y_d(iir_nxt[g])
        );
    end

    always_comb begin
        d = q;
        if (ref_en) begin
            unique case (q.mode)
                MODE_ACQ: begin
                    if (track) begin
                        d.mode  = MODE_TRK;
                        d.integ = preload_trk;
                        for (int i = 0; i < N_IIR; i++) begin
                            d.iir[i] = q.out;
                        end
                    end else begin
                        d.out = acq_out;
                    end
                end
                MODE_TRK: begin
                    if (!track) begin
                        d.mode  = MODE_ACQ;
                        d.integ = preload_acq;
                    end else begin
                        d.integ = integ_trk;
                        d.iir   = iir_nxt;
                        d.out   = iir_nxt[N_IIR-1];
                    end
                end
                default: d = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tune_word   = q.out;
    assign mode_is_trk = (q.mode == MODE_TRK);
    assign integ_obs   = q.integ;
endmodule

// File: rtl/lf_filter_checker.sv
module lf_filter_checker #(
    parameter int TW_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ref_en,
    input logic            track,
    input logic            in_trk,
    input logic [TW_W-1:0] integ,
    input logic [TW_W-1:0] tune_word
);
    // R1: reset clears the output
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (tune_word == '0));

    // R2: no strobe, no change of output or integrator
    a_r2_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |=> $stable(tune_word));
    a_r2_hold_integ: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |=> $stable(integ));

    // R3: integrator frozen while acquiring
    a_r3_integ_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_trk && !track) |=> $stable(integ));

    // R4: hitless entry to tracking
    a_r4_hitless_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && track && !in_trk) |=> ($stable(tune_word) && in_trk));

    // R7: hitless return to acquisition
    a_r7_hitless_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && !track && in_trk) |=> ($stable(tune_word) && !in_trk));
endmodule

bind gear_loop_filter lf_filter_checker #(.TW_W(TW_W)) u_lf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .track    (track),
    .in_trk   (mode_is_trk),
    .integ    (integ_obs),
    .tune_word(tune_word)
);

// File: tb/tb_gear_loop_filter.sv
module tb_gear_loop_filter;
    localparam int PE_W  = 10;
    localparam int TW_W  = 14;
    localparam int SH_W  = 4;
    localparam int N_IIR = 4;
    localparam int WMAX  = (1 << (TW_W - 1)) - 1;
    localparam int WMIN  = -(1 << (TW_W - 1));

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  ref_en = 1'b0;
    logic                  track = 1'b0;
    logic [PE_W-1:0]       phase_err = '0;
    logic [SH_W-1:0]       acq_kp_sh = '0;
    logic [SH_W-1:0]       trk_kp_sh = '0;
    logic [SH_W-1:0]       trk_ki_sh = '0;
    logic [N_IIR*SH_W-1:0] iir_k = '0;
    logic [TW_W-1:0]       tune_word;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model state
    int m_trk = 0;
    int m_int = 0;
    int m_out = 0;
    int m_y[N_IIR];

    always #10 clk = ~clk;

    gear_loop_filter #(.PE_W(PE_W), .TW_W(TW_W), .SH_W(SH_W), .N_IIR(N_IIR)) dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .track(track),
        .phase_err(phase_err), .acq_kp_sh(acq_kp_sh), .trk_kp_sh(trk_kp_sh),
        .trk_ki_sh(trk_ki_sh), .iir_k(iir_k), .tune_word(tune_word));

    function automatic int sat(int v);
        if (v > WMAX) return WMAX;
        if (v < WMIN) return WMIN;
        return v;
    endfunction

    function automatic int shr(int v, int k);
        return v >>> k;
    endfunction

    function automatic int kof(int i);
        return int'(iir_k[i*SH_W +: SH_W]);
    endfunction

    task automatic check(string tag);
        int act;
        act = int'($signed(tune_word));
        checks++;
        if (act !== m_out) begin
            failures++;
            $display("FAIL %s: tune_word=%0d expected=%0d", tag, act, m_out);
        end
    endtask

    // One clock: drive, advance model, wait one edge, sample on falling edge
    task automatic step(bit r, bit t, int pe, string tag);
        ref_en    = r;
        track     = t;
        phase_err = pe[PE_W-1:0];
        if (r) begin
            if (m_trk == 0) begin
                if (t) begin
                    m_int = sat(m_out - shr(pe, int'(trk_kp_sh)));
                    for (int i = 0; i < N_IIR; i++) m_y[i] = m_out;
                    m_trk = 1;
                end else begin
                    m_out = sat(m_int + shr(pe, int'(acq_kp_sh)));
                end
            end else begin
                if (!t) begin
                    m_int = sat(m_out - shr(pe, int'(acq_kp_sh)));
                    m_trk = 0;
                end else begin
                    int pi;
                    m_int = sat(m_int + shr(pe, int'(trk_ki_sh)));
                    pi = sat(m_int + shr(pe, int'(trk_kp_sh)));
                    for (int i = N_IIR - 1; i > 0; i--)
                        m_y[i] = m_y[i] + shr(m_y[i-1] - m_y[i], kof(i));
                    m_y[0] = m_y[0] + shr(pi - m_y[0], kof(0));
                    m_out = m_y[N_IIR-1];
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic set_iir(int k0, int k1, int k2, int k3);
        iir_k = {k3[SH_W-1:0], k2[SH_W-1:0], k1[SH_W-1:0], k0[SH_W-1:0]};
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            report();
        end
    end

    initial begin
        for (int i = 0; i < N_IIR; i++) m_y[i] = 0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset");
        ref_en = 1'b1;
        phase_err = 10'sd200;
        @(negedge clk);
        check("R1 reset with strobe");
        ref_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // R3: acquisition sweep over shifts and error values
        for (int k = 0; k < 6; k++) begin
            acq_kp_sh = k[SH_W-1:0];
            for (int pe = -512; pe < 512; pe += 37) step(1, 0, pe, "R3 acq sweep");
            step(1, 0, -1, "R3 floor shift");
            step(1, 0, 511, "R3 max error");
        end

        // R2: no strobe, inputs wiggle including a tracking request
        acq_kp_sh = 4'd1;
        step(1, 0, 300, "R3 set level");
        for (int i = 0; i < 10; i++) begin
            trk_ki_sh = i[SH_W-1:0];
            step(0, i[0], (i * 97) % 500 - 250, "R2 hold");
        end

        // R4: hitless entry, then expose the preloaded integrator
        trk_kp_sh = 4'd2;
        trk_ki_sh = 4'd4;
        set_iir(1, 2, 3, 2);
        step(1, 1, 100, "R4 hitless entry");
        set_iir(0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 1, 0, "R4 preload seen via R6 cascade");

        // R5/R6: tracking with varied error pattern and stage shifts
        set_iir(1, 2, 3, 2);
        trk_kp_sh = 4'd1;
        trk_ki_sh = 4'd3;
        for (int i = 0; i < 240; i++) begin
            if (i == 120) set_iir(3, 0, 5, 1);
            if (i % 7 == 6) step(0, 1, 333, "R2 hold in tracking");
            else step(1, 1, ((i * 53) % 400) - 200, "R5 R6 tracking");
        end

        // R8: saturation in tracking, both directions
        trk_ki_sh = 4'd0;
        trk_kp_sh = 4'd0;
        set_iir(0, 1, 0, 1);
        for (int i = 0; i < 40; i++) step(1, 1, 511, "R8 positive clamp");
        for (int i = 0; i < 60; i++) step(1, 1, -512, "R8 negative clamp");

        // R7: hitless return, then acquisition around the preload
        acq_kp_sh = 4'd2;
        step(1, 0, 200, "R7 hitless return");
        step(1, 0, 0, "R7 preload seen via R3");
        for (int pe = -512; pe < 512; pe += 61) step(1, 0, pe, "R3 acq offset");

        // R8: saturation in acquisition
        for (int i = 0; i < 40; i++) step(1, 1, 511, "R8 drive high");
        acq_kp_sh = 4'd0;
        step(1, 0, -512, "R7 return near limit");
        step(1, 0, 511, "R8 acq clamp high");
        step(1, 0, -512, "R3 acq below limit");

        done = 1;
        report();
    end
endmodule